// File: doc/BRIEF.md
# Transmit Flow-Control Gate

This block decides, cycle by cycle, whether the next byte may move from a transmit source into a serial transmitter. It merges two pacing schemes. The first is a hardware clear-to-send level. The second is in-band software pacing, where the far end sends a stop byte (0x13) or a resume byte (0x11) in the received stream. The block watches the received byte stream with its per-byte error flags. It forwards clean bytes to the receive path, and it uses the same clean bytes to keep a "blocked" flag for software pacing.

When clear-to-send comes back after a drop, transmission does not restart at once. A backoff counter is loaded with 2 and counts down on a periodic tick. This adds hysteresis to the hardware handshake. Each consecutive run of transfers is limited to a maximum length, so a long queue cannot hold the transmit path for ever. A run also ends early when the transmitter has no room or the source runs dry. A single strobe, `byte_go`, both starts the transmitter on a byte and pops that byte from the source.

Top module: `tx_flow_gate`

## Requirements
- R1: A received byte with `rx_valid` high and none of `rx_brk`, `rx_par`, `rx_frm` set appears on `fwd_byte` with `fwd_valid` high in the next cycle. This includes the pacing bytes 0x11 and 0x13.
- R2: A received byte with any error flag set gives no `fwd_valid` in the next cycle and has no effect on the blocked state, even when it is 0x13 or 0x11.
- R3: With `sw_flow_en` high, a clean 0x13 in cycle t keeps `byte_go` low from cycle t+1 on. A later clean 0x11 releases the gate from the cycle after it.
- R4: While `sw_flow_en` is low, 0x13 and 0x11 have no gating effect. Lowering `sw_flow_en` clears a blocked state from the next cycle.
- R5: With `hw_flow_en` high, `cts_in` low in cycle t keeps `byte_go` low in cycle t+1.
- R6: With `hw_flow_en` low, `cts_in` is ignored and any pending backoff is discarded from the next cycle.
- R7: With `hw_flow_en` high, `cts_in` low in cycle t-1 and high in cycle t loads a backoff of 2. `byte_go` stays low until two `tick` pulses have arrived in cycles after t, and may rise in the cycle after the second pulse. A tick in cycle t itself does not count.
- R8: `byte_go` is high only in a cycle where `tx_room` and `src_avail` are both high and the gate is open.
- R9: `byte_go` is never high for more than 128 consecutive cycles. After a run of 128 it is low for at least one cycle.
- R10: After reset the block is not blocked, treats clear-to-send as asserted, has no backoff pending and holds `fwd_valid` low. `byte_go` may therefore rise in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_byte | input | 8 | Received byte value |
| rx_brk | input | 1 | Received byte came with a break condition |
| rx_par | input | 1 | Received byte had a parity error |
| rx_frm | input | 1 | Received byte had a framing error |
| sw_flow_en | input | 1 | Enable in-band stop/resume pacing |
| hw_flow_en | input | 1 | Enable clear-to-send pacing |
| cts_in | input | 1 | Clear-to-send level, high = asserted, synchronous |
| tick | input | 1 | Periodic backoff tick, one cycle wide |
| tx_room | input | 1 | Transmitter can accept a byte |
| src_avail | input | 1 | Transmit source holds a byte |
| byte_go | output | 1 | Start transmission of, and pop, one byte this cycle |
| fwd_valid | output | 1 | Forwarded received byte valid |
| fwd_byte | output | 8 | Forwarded received byte |

## Verification
The bench targets the backoff edges. It checks a tick in the same cycle as the clear-to-send rise, which must not count, and it disables hardware pacing in the middle of a backoff. A design that counted the same-cycle tick would release one tick early. A design that kept the counter would stall with pacing off. It sends pacing bytes with error flags set, which must neither block nor be forwarded, and it lowers the software enable while blocked, which must release the gate. A design that got the run limit wrong by one shows up as a run of 127 or 129 transfers in the 140-cycle directed stream.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
    // Per-byte receive error flags
    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } rx_err_t;

    localparam logic [7:0] STOP_CODE_DEF   = 8'h13;
    localparam logic [7:0] RESUME_CODE_DEF = 8'h11;
endpackage

// File: rtl/tfg_rx_filter.sv
module tfg_rx_filter
    import tfg_pkg::*;
#(
    parameter int          DW    = 8,
    parameter logic [DW-1:0] XON  = DW'(RESUME_CODE_DEF),
    parameter logic [DW-1:0] XOFF = DW'(STOP_CODE_DEF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  rx_err_t       in_err,
    output logic          hit_stop,
    output logic          hit_resume,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } fwd_t;

    fwd_t st_d, st_q;
    logic clean;

    always_comb begin
        clean      = in_valid && (in_err == '0);
        hit_stop   = clean && (in_data == XOFF);
        hit_resume = clean && (in_data == XON);
        st_d       = st_q;
        st_d.valid = clean;
        if (clean) st_d.data = in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
endmodule

// File: rtl/tfg_cts_backoff.sv
module tfg_cts_backoff #(
    parameter int BACKOFF_TICKS = 2,
    localparam int BO_W = $clog2(BACKOFF_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_en,
    input  logic cts_in,
    input  logic tick,
    output logic cts_ok
);
    typedef struct packed {
        logic            cts;
        logic [BO_W-1:0] bo;
    } cts_st_t;

    cts_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hw_en) begin
            st_d.cts = 1'b1;
            st_d.bo  = '0;
        end else begin
            if (!st_q.cts && cts_in)
                st_d.bo = BO_W'(BACKOFF_TICKS);
            else if (tick && (st_q.bo != '0))
                st_d.bo = st_q.bo - 1'b1;
            st_d.cts = cts_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cts <= 1'b1;
            st_q.bo  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cts_ok = st_q.cts && (st_q.bo == '0);
endmodule

// File: rtl/tfg_burst.sv
module tfg_burst #(
    parameter int BURST_MAX = 128,
    localparam int CNT_W = $clog2(BURST_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic permit,
    input  logic room,
    input  logic avail,
    output logic go
);
    typedef struct packed {
        logic [CNT_W-1:0] run;
    } burst_st_t;

    burst_st_t st_d, st_q;

    always_comb begin
        go = permit && room && avail && (st_q.run < CNT_W'(BURST_MAX));
        st_d.run = go ? st_q.run + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tx_flow_gate.sv
module tx_flow_gate
    import tfg_pkg::*;
#(
    parameter int            DW            = 8,
    parameter int            BURST_MAX     = 128,
    parameter int            BACKOFF_TICKS = 2,
    parameter logic [DW-1:0] XON_CODE      = DW'(RESUME_CODE_DEF),
    parameter logic [DW-1:0] XOFF_CODE     = DW'(STOP_CODE_DEF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_brk,
    input  logic          rx_par,
    input  logic          rx_frm,
    input  logic          sw_flow_en,
    input  logic          hw_flow_en,
    input  logic          cts_in,
    input  logic          tick,
    input  logic          tx_room,
    input  logic          src_avail,
    output logic          byte_go,
    output logic          fwd_valid,
    output logic [DW-1:0] fwd_byte
);
    typedef struct packed {
        logic blocked;
    } gate_st_t;

    gate_st_t st_d, st_q;
    rx_err_t  err;
    logic     hit_stop, hit_resume, cts_ok, permit;

    assign err = '{brk: rx_brk, par: rx_par, frm: rx_frm};

    tfg_rx_filter #(.DW(DW), .XON(XON_CODE), .XOFF(XOFF_CODE)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_data(rx_byte), .in_err(err),
        .hit_stop(hit_stop), .hit_resume(hit_resume),
        .out_valid(fwd_valid), .out_data(fwd_byte)
    );

    tfg_cts_backoff #(.BACKOFF_TICKS(BACKOFF_TICKS)) u_cts (
        .clk(clk), .rst_n(rst_n),
        .hw_en(hw_flow_en), .cts_in(cts_in), .tick(tick),
        .cts_ok(cts_ok)
    );

    always_comb begin
        st_d = st_q;
        if (!sw_flow_en)      st_d.blocked = 1'b0;
        else if (hit_stop)    st_d.blocked = 1'b1;
        else if (hit_resume)  st_d.blocked = 1'b0;
        permit = !st_q.blocked && cts_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tfg_burst #(.BURST_MAX(BURST_MAX)) u_burst (
        .clk(clk), .rst_n(rst_n),
        .permit(permit), .room(tx_room), .avail(src_avail),
        .go(byte_go)
    );
endmodule

// File: rtl/tfg_checker.sv
module tfg_checker #(
    parameter int            DW        = 8,
    parameter int            BURST_MAX = 128,
    parameter logic [DW-1:0] XOFF      = 8'h13,
    localparam int           CNT_W     = $clog2(BURST_MAX + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [DW-1:0] rx_byte,
    input logic          rx_brk,
    input logic          rx_par,
    input logic          rx_frm,
    input logic          sw_flow_en,
    input logic          hw_flow_en,
    input logic          cts_in,
    input logic          tx_room,
    input logic          src_avail,
    input logic          byte_go,
    input logic          fwd_valid,
    input logic [DW-1:0] fwd_byte
);
    logic             up_q;
    logic [CNT_W-1:0] run_q;
    logic             clean;

    assign clean = rx_valid && !rx_brk && !rx_par && !rx_frm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q  <= 1'b0;
            run_q <= '0;
        end else begin
            up_q  <= 1'b1;
            run_q <= byte_go ? run_q + 1'b1 : '0;
        end
    end

    a_r1_forward: assert property (@(posedge clk) disable iff (!rst_n)
        clean |=> (fwd_valid && fwd_byte == $past(rx_byte)));

    a_r2_drop_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !clean) |=> !fwd_valid);

    a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_flow_en && clean && rx_byte == XOFF) |=> !byte_go);

    a_r5_cts_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow_en && !cts_in) |=> !byte_go);

    a_r7_backoff: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && hw_flow_en && $past(hw_flow_en) && !$past(cts_in) && cts_in) |=> !byte_go);

    a_r8_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        byte_go |-> (tx_room && src_avail));

    a_r9_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_go |-> (run_q < CNT_W'(BURST_MAX)));
endmodule

bind tx_flow_gate tfg_checker #(.DW(DW), .BURST_MAX(BURST_MAX), .XOFF(XOFF_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_brk(rx_brk), .rx_par(rx_par), .rx_frm(rx_frm),
    .sw_flow_en(sw_flow_en), .hw_flow_en(hw_flow_en), .cts_in(cts_in),
    .tx_room(tx_room), .src_avail(src_avail), .byte_go(byte_go),
    .fwd_valid(fwd_valid), .fwd_byte(fwd_byte)
);

// File: tb/tx_flow_gate_tb.sv
module tx_flow_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_brk = 0, rx_par = 0, rx_frm = 0;
    logic [7:0] rx_byte = '0;
    logic       sw_flow_en = 0, hw_flow_en = 0, cts_in = 1, tick = 0;
    logic       tx_room = 0, src_avail = 0;
    logic       byte_go, fwd_valid;
    logic [7:0] fwd_byte;

    int n_tests = 0, n_fail = 0;

    // reference state, built from the requirements
    logic       m_blk, m_cts, m_fv;
    int         m_bo, m_run;
    logic [7:0] m_fb;

    always #10 clk = ~clk;

    tx_flow_gate u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_brk(rx_brk), .rx_par(rx_par), .rx_frm(rx_frm),
        .sw_flow_en(sw_flow_en), .hw_flow_en(hw_flow_en), .cts_in(cts_in),
        .tick(tick), .tx_room(tx_room), .src_avail(src_avail),
        .byte_go(byte_go), .fwd_valid(fwd_valid), .fwd_byte(fwd_byte)
    );

    function automatic logic exp_go();
        return !m_blk && m_cts && (m_bo == 0) && (m_run < 128) && tx_room && src_avail;
    endfunction

    function automatic string why_tag();
        if (!(tx_room && src_avail)) return "R8";
        if (m_blk)                   return "R3";
        if (!m_cts)                  return "R5";
        if (m_bo != 0)               return "R7";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        logic clean;
        clean = rx_valid && !rx_brk && !rx_par && !rx_frm;
        if (exp_go()) m_run++; else m_run = 0;
        if (!sw_flow_en) m_blk = 0;
        else if (clean && rx_byte == 8'h13) m_blk = 1;
        else if (clean && rx_byte == 8'h11) m_blk = 0;
        if (!hw_flow_en) begin
            m_cts = 1; m_bo = 0;
        end else begin
            if (!m_cts && cts_in) m_bo = 2;
            else if (tick && m_bo > 0) m_bo--;
            m_cts = cts_in;
        end
        m_fv = clean;
        if (clean) m_fb = rx_byte;
    endtask

    // inputs already set just after a falling edge; check, update, advance
    task automatic step(input string tag);
        string t;
        #2;
        t = (tag == "") ? why_tag() : tag;
        check(t, {7'd0, byte_go}, {7'd0, exp_go()});
        check((tag == "") ? (m_fv ? "R1" : "R2") : tag, {7'd0, fwd_valid}, {7'd0, m_fv});
        if (m_fv) check((tag == "") ? "R1" : tag, fwd_byte, m_fb);
        model_update();
        @(negedge clk);
    endtask

    task automatic rx(input logic [7:0] b, input logic e);
        rx_valid = 1; rx_byte = b; rx_par = e;
    endtask

    task automatic rx_idle();
        rx_valid = 0; rx_brk = 0; rx_par = 0; rx_frm = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_blk = 0; m_cts = 1; m_bo = 0; m_run = 0; m_fv = 0; m_fb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: first cycle after reset
        hw_flow_en = 1; cts_in = 1; tx_room = 1; src_avail = 1;
        step("R10");
        // R1: clean bytes, including pacing codes with pacing off
        rx(8'h5A, 0); step("R1");
        rx(8'h13, 0); step("R1");
        rx(8'h11, 0); step("R1");
        rx_idle(); step("R1");
        // R2: errored pacing bytes with software pacing on
        sw_flow_en = 1;
        rx(8'h13, 1); step("R2");
        rx_valid = 1; rx_byte = 8'h13; rx_par = 0; rx_frm = 1; step("R2");
        rx_frm = 0; rx_brk = 1; step("R2");
        rx_idle(); step("R2"); step("R2");
        // R3: stop, hold, resume
        rx(8'h13, 0); step("R3");
        rx_idle(); step("R3"); step("R3");
        rx(8'h11, 0); step("R3");
        rx_idle(); step("R3");
        // R4: lowering the enable releases; codes ignored while off
        rx(8'h13, 0); step("R4");
        rx_idle(); sw_flow_en = 0; step("R4"); step("R4");
        rx(8'h13, 0); step("R4");
        rx_idle(); step("R4"); step("R4");
        // R5 and R7: drop, rise with same-cycle tick, then two ticks
        cts_in = 0; step("R5"); step("R5");
        cts_in = 1; tick = 1; step("R7");
        tick = 0; step("R7"); step("R7");
        tick = 1; step("R7");
        tick = 0; step("R7");
        tick = 1; step("R7");
        tick = 0; step("R7"); step("R7");
        // R6: pacing off ignores the level and drops a pending backoff
        hw_flow_en = 0; cts_in = 0; step("R6"); step("R6");
        hw_flow_en = 1; step("R6");
        cts_in = 1; step("R6"); step("R6");
        hw_flow_en = 0; step("R6"); step("R6"); step("R6");
        // R9: long stream with pacing off
        cts_in = 1;
        for (int i = 0; i < 140; i++) step("R9");
        // R8: no room or empty source
        tx_room = 0; step("R8");
        tx_room = 1; src_avail = 0; step("R8");
        src_avail = 1; step("R8");
        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            rx_valid = (r < 40);
            case ($urandom_range(0, 3))
                0: rx_byte = 8'h13;
                1: rx_byte = 8'h11;
                default: rx_byte = 8'($urandom);
            endcase
            rx_brk = ($urandom_range(0, 9) == 0);
            rx_par = ($urandom_range(0, 9) == 0);
            rx_frm = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 49) == 0) sw_flow_en = ~sw_flow_en;
            if ($urandom_range(0, 99) == 0) hw_flow_en = ~hw_flow_en;
            if ($urandom_range(0, 19) == 0) cts_in = ~cts_in;
            tick      = ($urandom_range(0, 4) == 0);
            tx_room   = ($urandom_range(0, 9) != 0);
            src_avail = ($urandom_range(0, 19) != 0);
            step("");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule